// File: doc/BRIEF.md
# Display Bridge Bring-Up Sequencer

This block powers up an external RGB-to-DSI display bridge through a register master that handles the serial framing. After a start pulse it holds the bridge in reset and then waits out a settle time. If the board can read back from the bridge, it next confirms the identity and configuration words. It then writes the parallel video timing, pixel format, lane count, link configuration, PLL and clock settings. It waits for the PLL to lock and sends the panel its exit-sleep and display-on commands, with a programmable pause after each. In the last step it turns on high-speed data lanes and the video pipeline.

The timing fields, the PLL word and the low-power divider word are computed elsewhere and arrive as inputs. The sequencer issues one register access at a time. It holds the request until the register master acknowledges it, and it ends with a sticky done or error flag. It keeps a shadow copy of the bridge configuration word, so the two configuration writes are derived from the reset value and not read back.

Top module: `disp_bridge_seq`

## Requirements
- R1: After reset `bridge_rst_n` is 1, and `req`, `done` and `error` are 0.
- R2: A start pulse drives `bridge_rst_n` low for at least RST_LO_CYC and at most RST_LO_CYC+2 cycles. It then stays high for at least RST_HI_CYC cycles before the first request. No request is raised while `bridge_rst_n` is low.
- R3: A request keeps `req` high, with `req_wr`, `req_addr` and `req_wdata` unchanged, until the cycle in which `ack` is high. Only one access is outstanding at a time.
- R4: With `chk_en`=1 the first two accesses are reads (`req_wr`=0): address 0xB0, which must return 0x2828, and address 0xB7, which must return 0x0301. A mismatch sets `error` and no further request is made. With `chk_en`=0 no read is issued.
- R5: The timing writes are made in this order, with values {high byte, low byte}:
  - 0xB1 = {sync_v, sync_h}
  - 0xB2 = {sync_v+vbp, sync_h+hbp}, each sum taken modulo 256
  - 0xB3 = {vfp, hfp}
  - 0xB4 = act_w
  - 0xB5 = act_h
- R6: The next write is 0xB6 = 0x0008 | code. The code is 0 for depth 16, 1 for depth 18 with `px_loose`=0, 2 for depth 18 with `px_loose`=1, and 3 for depth 24. Any other depth sets `error` after the 0xB5 write, and 0xB6 is not written.
- R7: The next write is 0xDE = lane_cnt - 1.
- R8: The next writes, in order, are:
  - 0xB7 = 0x0342: the reset word 0x0301 with bit 0 cleared and bits 1 and 6 set
  - 0xBA = pll_word
  - 0xB8 = 0
  - 0xBB = lp_div
  - 0xB9 = 1
- R9: After the 0xB9 write is acknowledged, the next request appears no earlier than LOCK_CYC+1 and no later than LOCK_CYC+8 cycles after the acknowledging cycle.
- R10: The command phase runs in this order:
  - Write 0xBC = 1, then 0xBF = 0x11.
  - Pause between sleep_wait+1 and sleep_wait+8 cycles after the acknowledge.
  - Write 0xBC = 1, then 0xBF = 0x29.
  - Pause between disp_wait+1 and disp_wait+8 cycles.
- R11: The final write is 0xB7 = 0x034B, the shadow with bits 0 and 3 also set. `done` then rises and stays high, and no further request is made. `done` and `error` are never both 1.
- R12: A start pulse while a sequence is running has no effect. A start pulse after done or error clears both flags and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (pulse) |
| chk_en | input | 1 | Readback is available; perform the identity and configuration checks |
| sync_v | input | 8 | Vertical sync length in lines |
| sync_h | input | 8 | Horizontal sync length in pixels |
| vbp | input | 8 | Vertical back margin |
| hbp | input | 8 | Horizontal back margin |
| vfp | input | 8 | Vertical front margin |
| hfp | input | 8 | Horizontal front margin |
| act_w | input | 16 | Active width |
| act_h | input | 16 | Active height |
| px_depth | input | 5 | Colour depth in bits per pixel |
| px_loose | input | 1 | Loose packing for 18 bpp |
| lane_cnt | input | 3 | Number of data lanes (1 to 4) |
| pll_word | input | 16 | Precomputed PLL configuration word |
| lp_div | input | 16 | Precomputed low-power clock divider word |
| sleep_wait | input | WAIT_W | Cycles to wait after exit-sleep |
| disp_wait | input | WAIT_W | Cycles to wait after display-on |
| bridge_rst_n | output | 1 | Active-low reset to the bridge |
| req | output | 1 | Register access request |
| req_wr | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Register address |
| req_wdata | output | 16 | Write data |
| ack | input | 1 | Register master completion (one cycle) |
| rdata | input | 16 | Read data, valid with `ack` |
| done | output | 1 | Sequence completed (sticky) |
| error | output | 1 | Sequence aborted (sticky) |

## Verification
Full sequences are run with random timing fields, PLL words and wait lengths under every valid pixel format and lane count. Each run uses a random acknowledge latency, so ordering and request holding are tested apart from the master's speed. Directed runs cover:
- a wrong identity word, which must stop after one access;
- a wrong configuration word, which must stop after two accesses;
- an unsupported depth, which must stop after the 0xB5 write and must not write 0xB6;
- zero-length waits, which separate the minimum pause from an off-by-one;
- a start pulse during the lock wait, which must leave the transaction list unchanged;
- a restart after an error, which must clear the flags.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int STEP_W = 5;

  localparam logic [7:0] ADR_ID     = 8'hB0;
  localparam logic [7:0] ADR_SYNC   = 8'hB1;
  localparam logic [7:0] ADR_BACK   = 8'hB2;
  localparam logic [7:0] ADR_FRONT  = 8'hB3;
  localparam logic [7:0] ADR_WIDTH  = 8'hB4;
  localparam logic [7:0] ADR_HEIGHT = 8'hB5;
  localparam logic [7:0] ADR_VMODE  = 8'hB6;
  localparam logic [7:0] ADR_CFG    = 8'hB7;
  localparam logic [7:0] ADR_VCH    = 8'hB8;
  localparam logic [7:0] ADR_PLLEN  = 8'hB9;
  localparam logic [7:0] ADR_PLLW   = 8'hBA;
  localparam logic [7:0] ADR_LPDIV  = 8'hBB;
  localparam logic [7:0] ADR_PKTLEN = 8'hBC;
  localparam logic [7:0] ADR_PKTDAT = 8'hBF;
  localparam logic [7:0] ADR_LANES  = 8'hDE;

  localparam logic [15:0] ID_WORD    = 16'h2828;
  localparam logic [15:0] CFG_RSTVAL = 16'h0301;
  localparam logic [15:0] BURST_MODE = 16'h0008;

  localparam int CB_DATA_HS  = 0;
  localparam int CB_CLK_HS   = 1;
  localparam int CB_VID_ON   = 3;
  localparam int CB_DCS_ONLY = 6;

  localparam logic [7:0] DCS_WAKE  = 8'h11;
  localparam logic [7:0] DCS_DISP  = 8'h29;

  typedef enum logic [2:0] {
    OP_WRITE,
    OP_READ,
    OP_VMODE,
    OP_CFG,
    OP_WAIT_LOCK,
    OP_WAIT_SLEEP,
    OP_WAIT_DISP,
    OP_END
  } op_t;

  typedef struct packed {
    op_t         op;
    logic [7:0]  addr;
    logic [15:0] data;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_RST_HI,
    ST_STEP,
    ST_XFER,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } seq_st_t;

endpackage

// File: rtl/dbs_timer.sv
module dbs_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt;
  logic         cnt_en;
  logic [W-1:0] cnt_nxt;

  assign zero = (cnt == '0);

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt;
    if (load) begin
      cnt_en  = 1'b1;
      cnt_nxt = load_val;
    end else if (dec && !zero) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/dbs_xfer.sv
module dbs_xfer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_wr,
  input  logic [7:0]  go_addr,
  input  logic [15:0] go_data,
  input  logic        ack,
  output logic        req,
  output logic        req_wr,
  output logic [7:0]  req_addr,
  output logic [15:0] req_wdata,
  output logic        fin
);

  assign fin = req & ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else if (go) begin
      req <= 1'b1;
    end else if (fin) begin
      req <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_wr    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (go) begin
      req_wr    <= go_wr;
      req_addr  <= go_addr;
      req_wdata <= go_data;
    end
  end

endmodule

// File: rtl/dbs_fmt_dec.sv
module dbs_fmt_dec (
  input  logic [4:0] depth,
  input  logic       loose,
  output logic [1:0] code,
  output logic       ok
);

  always_comb begin
    code = 2'd0;
    ok   = 1'b1;
    case (depth)
      5'd16:   code = 2'd0;
      5'd18:   code = loose ? 2'd2 : 2'd1;
      5'd24:   code = 2'd3;
      default: ok   = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbs_step_table.sv
module dbs_step_table
  import dbs_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  input  logic [7:0]        sync_v,
  input  logic [7:0]        sync_h,
  input  logic [7:0]        vbp,
  input  logic [7:0]        hbp,
  input  logic [7:0]        vfp,
  input  logic [7:0]        hfp,
  input  logic [15:0]       act_w,
  input  logic [15:0]       act_h,
  input  logic [1:0]        fmt_code,
  input  logic [2:0]        lane_cnt,
  input  logic [15:0]       pll_word,
  input  logic [15:0]       lp_div,
  input  logic [15:0]       shadow,
  output step_t             step
);

  logic [7:0]  back_v;
  logic [7:0]  back_h;
  logic [2:0]  lane_m1;
  logic [15:0] cfg_setup;
  logic [15:0] cfg_final;

  assign back_v  = sync_v + vbp;
  assign back_h  = sync_h + hbp;
  assign lane_m1 = lane_cnt - 3'd1;

  always_comb begin
    cfg_setup = shadow;
    cfg_setup[CB_DATA_HS]  = 1'b0;
    cfg_setup[CB_CLK_HS]   = 1'b1;
    cfg_setup[CB_DCS_ONLY] = 1'b1;
    cfg_final = shadow;
    cfg_final[CB_DATA_HS]  = 1'b1;
    cfg_final[CB_VID_ON]   = 1'b1;
  end

  always_comb begin
    step = '{op: OP_END, addr: 8'h00, data: 16'h0000};
    case (idx)
      5'd0:  step = '{op: OP_READ,  addr: ADR_ID,     data: ID_WORD};
      5'd1:  step = '{op: OP_READ,  addr: ADR_CFG,    data: CFG_RSTVAL};
      5'd2:  step = '{op: OP_WRITE, addr: ADR_SYNC,   data: {sync_v, sync_h}};
      5'd3:  step = '{op: OP_WRITE, addr: ADR_BACK,   data: {back_v, back_h}};
      5'd4:  step = '{op: OP_WRITE, addr: ADR_FRONT,  data: {vfp, hfp}};
      5'd5:  step = '{op: OP_WRITE, addr: ADR_WIDTH,  data: act_w};
      5'd6:  step = '{op: OP_WRITE, addr: ADR_HEIGHT, data: act_h};
      5'd7:  step = '{op: OP_VMODE, addr: ADR_VMODE,  data: BURST_MODE | {14'd0, fmt_code}};
      5'd8:  step = '{op: OP_WRITE, addr: ADR_LANES,  data: {13'd0, lane_m1}};
      5'd9:  step = '{op: OP_CFG,   addr: ADR_CFG,    data: cfg_setup};
      5'd10: step = '{op: OP_WRITE, addr: ADR_PLLW,   data: pll_word};
      5'd11: step = '{op: OP_WRITE, addr: ADR_VCH,    data: 16'h0000};
      5'd12: step = '{op: OP_WRITE, addr: ADR_LPDIV,  data: lp_div};
      5'd13: step = '{op: OP_WRITE, addr: ADR_PLLEN,  data: 16'h0001};
      5'd14: step = '{op: OP_WAIT_LOCK,  addr: 8'h00, data: 16'h0000};
      5'd15: step = '{op: OP_WRITE, addr: ADR_PKTLEN, data: 16'h0001};
      5'd16: step = '{op: OP_WRITE, addr: ADR_PKTDAT, data: {8'd0, DCS_WAKE}};
      5'd17: step = '{op: OP_WAIT_SLEEP, addr: 8'h00, data: 16'h0000};
      5'd18: step = '{op: OP_WRITE, addr: ADR_PKTLEN, data: 16'h0001};
      5'd19: step = '{op: OP_WRITE, addr: ADR_PKTDAT, data: {8'd0, DCS_DISP}};
      5'd20: step = '{op: OP_WAIT_DISP,  addr: 8'h00, data: 16'h0000};
      5'd21: step = '{op: OP_CFG,   addr: ADR_CFG,    data: cfg_final};
      default: step = '{op: OP_END, addr: 8'h00, data: 16'h0000};
    endcase
  end

endmodule

// File: rtl/disp_bridge_seq.sv
module disp_bridge_seq
  import dbs_pkg::*;
#(
  parameter int RST_LO_CYC = 1000000,
  parameter int RST_HI_CYC = 1000000,
  parameter int LOCK_CYC   = 50000,
  parameter int WAIT_W     = 24,
  parameter int TMR_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chk_en,
  input  logic [7:0]        sync_v,
  input  logic [7:0]        sync_h,
  input  logic [7:0]        vbp,
  input  logic [7:0]        hbp,
  input  logic [7:0]        vfp,
  input  logic [7:0]        hfp,
  input  logic [15:0]       act_w,
  input  logic [15:0]       act_h,
  input  logic [4:0]        px_depth,
  input  logic              px_loose,
  input  logic [2:0]        lane_cnt,
  input  logic [15:0]       pll_word,
  input  logic [15:0]       lp_div,
  input  logic [WAIT_W-1:0] sleep_wait,
  input  logic [WAIT_W-1:0] disp_wait,
  output logic              bridge_rst_n,
  output logic              req,
  output logic              req_wr,
  output logic [7:0]        req_addr,
  output logic [15:0]       req_wdata,
  input  logic              ack,
  input  logic [15:0]       rdata,
  output logic              done,
  output logic              error
);

  localparam logic [TMR_W-1:0] T_RST_LO = TMR_W'(RST_LO_CYC);
  localparam logic [TMR_W-1:0] T_RST_HI = TMR_W'(RST_HI_CYC);
  localparam logic [TMR_W-1:0] T_LOCK   = TMR_W'(LOCK_CYC);

  seq_st_t           st, st_n;
  logic [STEP_W-1:0] idx, idx_n;
  logic [15:0]       shadow;
  logic              done_n, err_n;
  logic              accept;
  logic              go;
  logic              shadow_ld;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              fin;
  logic [1:0]        fmt_code;
  logic              fmt_ok;
  step_t             step;

  dbs_fmt_dec u_fmt (
    .depth (px_depth),
    .loose (px_loose),
    .code  (fmt_code),
    .ok    (fmt_ok)
  );

  dbs_step_table u_tbl (
    .idx      (idx),
    .sync_v   (sync_v),
    .sync_h   (sync_h),
    .vbp      (vbp),
    .hbp      (hbp),
    .vfp      (vfp),
    .hfp      (hfp),
    .act_w    (act_w),
    .act_h    (act_h),
    .fmt_code (fmt_code),
    .lane_cnt (lane_cnt),
    .pll_word (pll_word),
    .lp_div   (lp_div),
    .shadow   (shadow),
    .step     (step)
  );

  dbs_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  dbs_xfer u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_wr     (step.op != OP_READ),
    .go_addr   (step.addr),
    .go_data   (step.data),
    .ack       (ack),
    .req       (req),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .fin       (fin)
  );

  assign bridge_rst_n = (st != ST_RST_LO);
  assign tmr_dec      = (st == ST_RST_LO) || (st == ST_RST_HI) || (st == ST_WAIT);

  always_comb begin
    st_n      = st;
    idx_n     = idx;
    done_n    = done;
    err_n     = error;
    accept    = 1'b0;
    go        = 1'b0;
    shadow_ld = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (st)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          accept   = 1'b1;
          st_n     = ST_RST_LO;
          idx_n    = '0;
          done_n   = 1'b0;
          err_n    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = T_RST_LO;
        end
      end
      ST_RST_LO: begin
        if (tmr_zero) begin
          st_n     = ST_RST_HI;
          tmr_load = 1'b1;
          tmr_val  = T_RST_HI;
        end
      end
      ST_RST_HI: begin
        if (tmr_zero) st_n = ST_STEP;
      end
      ST_STEP: begin
        case (step.op)
          OP_READ: begin
            if (chk_en) begin
              go   = 1'b1;
              st_n = ST_XFER;
            end else begin
              idx_n = idx + STEP_W'(1);
            end
          end
          OP_WRITE: begin
            go   = 1'b1;
            st_n = ST_XFER;
          end
          OP_CFG: begin
            go        = 1'b1;
            shadow_ld = 1'b1;
            st_n      = ST_XFER;
          end
          OP_VMODE: begin
            if (fmt_ok) begin
              go   = 1'b1;
              st_n = ST_XFER;
            end else begin
              err_n = 1'b1;
              st_n  = ST_FAIL;
            end
          end
          OP_WAIT_LOCK: begin
            tmr_load = 1'b1;
            tmr_val  = T_LOCK;
            st_n     = ST_WAIT;
          end
          OP_WAIT_SLEEP: begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(sleep_wait);
            st_n     = ST_WAIT;
          end
          OP_WAIT_DISP: begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(disp_wait);
            st_n     = ST_WAIT;
          end
          default: begin
            done_n = 1'b1;
            st_n   = ST_DONE;
          end
        endcase
      end
      ST_XFER: begin
        if (fin) begin
          if ((step.op == OP_READ) && (rdata != step.data)) begin
            err_n = 1'b1;
            st_n  = ST_FAIL;
          end else begin
            idx_n = idx + STEP_W'(1);
            st_n  = ST_STEP;
          end
        end
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          idx_n = idx + STEP_W'(1);
          st_n  = ST_STEP;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      st    <= st_n;
      idx   <= idx_n;
      done  <= done_n;
      error <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= CFG_RSTVAL;
    end else if (accept) begin
      shadow <= CFG_RSTVAL;
    end else if (shadow_ld) begin
      shadow <= step.data;
    end
  end

endmodule

// File: rtl/dbs_seq_chk.sv
module dbs_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bridge_rst_n,
  input logic        req,
  input logic        req_wr,
  input logic [7:0]  req_addr,
  input logic [15:0] req_wdata,
  input logic        ack,
  input logic        done,
  input logic        error
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(req_addr) && $stable(req_wdata) && $stable(req_wr))); // R3

  AST_NO_REQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_rst_n |-> !req); // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R11

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error); // R4

  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !req); // R11

endmodule

bind disp_bridge_seq dbs_seq_chk u_seq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .bridge_rst_n (bridge_rst_n),
  .req          (req),
  .req_wr       (req_wr),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .ack          (ack),
  .done         (done),
  .error        (error)
);

// File: tb/disp_bridge_seq_test.sv
module disp_bridge_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int RLO  = 20;
  localparam int RHI  = 15;
  localparam int LOCK = 30;
  localparam int WW   = 24;
  localparam int LOGN = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          c_chk;
  logic [7:0]    c_sv, c_sh, c_vb, c_hb, c_vf, c_hf;
  logic [15:0]   c_w, c_h;
  logic [4:0]    c_depth;
  logic          c_loose;
  logic [2:0]    c_lanes;
  logic [15:0]   c_pll, c_lp;
  logic [WW-1:0] c_slp, c_dsp;
  logic          bridge_rst_n, req, req_wr, ack, done, error;
  logic [7:0]    req_addr;
  logic [15:0]   req_wdata, rdata;

  logic [15:0] id_val, cfg_val;
  int tests = 0, fails = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0]  log_addr [LOGN];
  logic        log_wr   [LOGN];
  logic [15:0] log_data [LOGN];
  int          rq_cyc   [LOGN];
  int          ack_cyc  [LOGN];
  int          log_n;
  logic [7:0]  exp_addr [LOGN];
  logic        exp_wr   [LOGN];
  logic [15:0] exp_data [LOGN];
  int          exp_n;
  bit          exp_err;
  int          rst_lo_n, rise_cyc;
  bit          viol, hold_bad, pend, prev_brst;
  int          lat;

  disp_bridge_seq #(
    .RST_LO_CYC(RLO), .RST_HI_CYC(RHI), .LOCK_CYC(LOCK), .WAIT_W(WW), .TMR_W(32)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_en(c_chk),
    .sync_v(c_sv), .sync_h(c_sh), .vbp(c_vb), .hbp(c_hb), .vfp(c_vf), .hfp(c_hf),
    .act_w(c_w), .act_h(c_h), .px_depth(c_depth), .px_loose(c_loose),
    .lane_cnt(c_lanes), .pll_word(c_pll), .lp_div(c_lp),
    .sleep_wait(c_slp), .disp_wait(c_dsp),
    .bridge_rst_n(bridge_rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .done(done), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'hB0:                             return "R4";
      8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5: return "R5";
      8'hB6:                             return "R6";
      8'hDE:                             return "R7";
      8'hBC, 8'hBF:                      return "R10";
      default:                           return "R8";
    endcase
  endfunction

  task automatic push(input logic w, input logic [7:0] a, input logic [15:0] d);
    exp_wr[exp_n] = w; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
  endtask

  // Expected transaction list, built from the requirements.
  task automatic build_exp();
    logic [7:0] bv, bh;
    logic [1:0] code;
    exp_n = 0; exp_err = 0;
    if (c_chk) begin
      push(1'b0, 8'hB0, 16'h2828);
      if (id_val != 16'h2828) begin exp_err = 1; return; end
      push(1'b0, 8'hB7, 16'h0301);
      if (cfg_val != 16'h0301) begin exp_err = 1; return; end
    end
    bv = c_sv + c_vb; bh = c_sh + c_hb;
    push(1'b1, 8'hB1, {c_sv, c_sh});
    push(1'b1, 8'hB2, {bv, bh});
    push(1'b1, 8'hB3, {c_vf, c_hf});
    push(1'b1, 8'hB4, c_w);
    push(1'b1, 8'hB5, c_h);
    case (c_depth)
      5'd16: code = 2'd0;
      5'd18: code = c_loose ? 2'd2 : 2'd1;
      5'd24: code = 2'd3;
      default: begin exp_err = 1; return; end
    endcase
    push(1'b1, 8'hB6, 16'h0008 | {14'd0, code});
    push(1'b1, 8'hDE, {13'd0, c_lanes - 3'd1});
    push(1'b1, 8'hB7, 16'h0342);
    push(1'b1, 8'hBA, c_pll);
    push(1'b1, 8'hB8, 16'h0000);
    push(1'b1, 8'hBB, c_lp);
    push(1'b1, 8'hB9, 16'h0001);
    push(1'b1, 8'hBC, 16'h0001);
    push(1'b1, 8'hBF, 16'h0011);
    push(1'b1, 8'hBC, 16'h0001);
    push(1'b1, 8'hBF, 16'h0029);
    push(1'b1, 8'hB7, 16'h034B);
  endtask

  // Register master model and port monitor.
  initial begin
    ack = 0; rdata = 0; pend = 0; prev_brst = 1; lat = 0;
    forever begin
      @(negedge clk);
      ack = 0;
      if (rst_n) begin
        if (!bridge_rst_n) rst_lo_n++;
        if (bridge_rst_n && !prev_brst) rise_cyc = cyc;
        if (req && !bridge_rst_n) viol = 1;
        if (req && !pend && log_n < LOGN) begin
          pend = 1; lat = int'($urandom % 4);
          log_addr[log_n] = req_addr; log_wr[log_n] = req_wr;
          log_data[log_n] = req_wdata; rq_cyc[log_n] = cyc;
        end else if (pend && (!req || req_addr != log_addr[log_n] ||
                              req_wdata != log_data[log_n] || req_wr != log_wr[log_n])) begin
          hold_bad = 1;
        end
        if (pend) begin
          if (lat == 0) begin
            ack = 1;
            rdata = (req_addr == 8'hB0) ? id_val : (req_addr == 8'hB7) ? cfg_val : 16'h0;
            ack_cyc[log_n] = cyc; log_n++; pend = 0;
          end else lat--;
        end
      end
      prev_brst = bridge_rst_n;
    end
  end

  task automatic run_seq(input bit mid);
    int base, pos, quiet_n;
    bit seen, pulsed;
    log_n = 0; rst_lo_n = 0; rise_cyc = -1; viol = 0; hold_bad = 0; pulsed = 0;
    build_exp();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(!done && !error, "R12 flags cleared by start", {done, error}, 0);
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      start = 0;
      if (done || error) begin seen = 1; break; end
      if (mid && !pulsed && log_n == (c_chk ? 14 : 12)) begin start = 1; pulsed = 1; end
    end
    check(seen, "R11 sequence finished", seen, 1);
    quiet_n = log_n;
    repeat (20) @(negedge clk);
    check(log_n == quiet_n, "R11 no request after end", log_n, quiet_n);
    check(error == exp_err, "R4/R6 error flag", error, exp_err);
    check(done == !exp_err, "R11 done flag", done, !exp_err);
    check(log_n == exp_n, "R3 transaction count", log_n, exp_n);
    check(!hold_bad, "R3 request held until ack", hold_bad, 0);
    check(!viol, "R2 no request in bridge reset", viol, 0);
    check(rst_lo_n >= RLO + 0 && rst_lo_n <= RLO + 2, "R2 reset low length", rst_lo_n, RLO);
    if (log_n > 0)
      check(rq_cyc[0] - rise_cyc >= RHI, "R2 settle before first access", rq_cyc[0] - rise_cyc, RHI);
    for (int k = 0; k < exp_n && k < log_n; k++) begin
      check(log_addr[k] == exp_addr[k], tag_of(exp_addr[k]), log_addr[k], exp_addr[k]);
      check(log_wr[k] == exp_wr[k], tag_of(exp_addr[k]), log_wr[k], exp_wr[k]);
      if (exp_wr[k])
        check(log_data[k] == exp_data[k], tag_of(exp_addr[k]), log_data[k], exp_data[k]);
    end
    if (!exp_err && log_n == exp_n) begin
      base = c_chk ? 2 : 0;
      pos = rq_cyc[base+12] - ack_cyc[base+11];
      check(pos >= LOCK + 1 && pos <= LOCK + 8, "R9 lock wait", pos, LOCK + 1);
      pos = rq_cyc[base+14] - ack_cyc[base+13];
      check(pos >= int'(c_slp) + 1 && pos <= int'(c_slp) + 8, "R10 sleep wait", pos, int'(c_slp) + 1);
      pos = rq_cyc[base+16] - ack_cyc[base+15];
      check(pos >= int'(c_dsp) + 1 && pos <= int'(c_dsp) + 8, "R10 display wait", pos, int'(c_dsp) + 1);
      check(log_data[exp_n-1] == 16'h034B, "R11 final configuration", log_data[exp_n-1], 16'h034B);
    end
  endtask

  task automatic rand_cfg();
    c_sv = 8'($urandom % 100); c_sh = 8'($urandom % 100);
    c_vb = 8'($urandom % 150); c_hb = 8'($urandom % 150);
    c_vf = 8'($urandom); c_hf = 8'($urandom);
    c_w = 16'($urandom); c_h = 16'($urandom);
    c_pll = 16'($urandom); c_lp = 16'($urandom);
    c_lanes = 3'(1 + $urandom % 4);
    c_slp = WW'($urandom % 60); c_dsp = WW'($urandom % 60);
    c_chk = 1'($urandom);
    case ($urandom % 4)
      0: begin c_depth = 5'd16; c_loose = 1'($urandom); end
      1: begin c_depth = 5'd18; c_loose = 1'b0; end
      2: begin c_depth = 5'd18; c_loose = 1'b1; end
      default: begin c_depth = 5'd24; c_loose = 1'($urandom); end
    endcase
    id_val = 16'h2828; cfg_val = 16'h0301;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; start = 0;
    rand_cfg();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bridge_rst_n == 1'b1, "R1 bridge reset idle high", bridge_rst_n, 1);
    check(!req && !done && !error, "R1 outputs idle", {req, done, error}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!req && !done && !error && bridge_rst_n, "R1 idle after release", {req, done, error}, 0);

    // Directed: 24 bpp, four lanes, readback on
    rand_cfg(); c_chk = 1; c_depth = 5'd24; c_lanes = 3'd4; run_seq(0);
    // Directed: 18 bpp loose, two lanes, readback off
    rand_cfg(); c_chk = 0; c_depth = 5'd18; c_loose = 1; c_lanes = 3'd2; run_seq(0);
    // Directed: 16 bpp, one lane, zero waits
    rand_cfg(); c_chk = 1; c_depth = 5'd16; c_lanes = 3'd1; c_slp = 0; c_dsp = 0; run_seq(0);
    // Directed: 18 bpp packed, margin sums wrap (R5)
    rand_cfg(); c_depth = 5'd18; c_loose = 0; c_sv = 8'd200; c_vb = 8'd100; c_sh = 8'd255; c_hb = 8'd1; run_seq(0);
    // Random runs
    for (int r = 0; r < 6; r++) begin rand_cfg(); run_seq(0); end
    // R4: wrong identity word
    rand_cfg(); c_chk = 1; id_val = 16'h2827; run_seq(0);
    // R12: restart after error, with R4 wrong configuration word
    cfg_val = 16'h0300; id_val = 16'h2828; run_seq(0);
    // R6: unsupported depth, with and without readback
    rand_cfg(); c_chk = 1; c_depth = 5'd20; run_seq(0);
    rand_cfg(); c_chk = 0; c_depth = 5'd8; run_seq(0);
    // R12: start pulse during the lock wait is ignored
    rand_cfg(); run_seq(1);
    rand_cfg(); c_chk = 0; run_seq(1);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule